// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block holds the power-control register of an 8-bit controller and runs the low-power state machine behind it. Software enters a sleep mode by writing that register. The block then gates the CPU clock, the peripheral clock and the oscillator. While the device sleeps it also holds the address-latch and program-store strobes at a fixed level.

Idle stops only the CPU clock, and any enabled interrupt request ends it. Power-down also stops the oscillator and the peripheral clock. Only reset ends it, or a qualifying external interrupt line that goes through a low-then-high sequence. When that sequence ends, the CPU clock stays off for a programmable settling count so that the restarted oscillator can stabilise.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The register reads back as bit 7 baud double, bit 6 framing-error select, bit 5 power-off flag, bit 4 watchdog arm, bits 3:2 general flags, bit 1 power-down request (PD), bit 0 idle request (IDL). Each bit reads what was last written, except where another requirement says otherwise.
- R2: Reset clears every register bit except bit 5, and leaves the block running with all clocks and the oscillator enabled. Bit 5 keeps its value through reset.
- R3: A write with both bit 1 and bit 0 set enters power-down, not idle. Only PD reads back as 1.
- R4: PD can be set only while `pd_permit` is high. If `pd_permit` is low, bit 1 of the write is dropped, and an IDL bit in the same write enters idle.
- R5: In idle, `cpu_clk_en` is low and `per_clk_en` stays high. A high `irq_pending` returns the block to run on the next edge and clears IDL.
- R6: In power-down, `cpu_clk_en`, `per_clk_en` and `osc_en` are all low. `irq_pending` and non-qualifying pins have no effect. Reset ends the mode.
- R7: A pin qualifies for wake-up only when its `xint_en` bit is 1, its `xint_level` bit is 1 (level mode), `wake_en` is 1, and it is low (`xint_n` = 0). A qualifying pin raises `osc_en` on the next edge, and `cpu_clk_en` stays low for as long as any pin still qualifies.
- R8: `strobe_hold` is 1 in every state except run. `strobe_level` is 1 in idle and 0 in all other states.
- R9: `wdt_load` clears bit 4 on the next edge, taking priority over a write in the same cycle.
- R10: Once no pin qualifies any longer, `cpu_clk_en` rises at the edge that comes `settle_limit`+1 edges after the edge that sampled the release.
- R11: PD clears in hardware at the same edge that returns the block to run after a wake-up.
- R12: Register writes are ignored while `cpu_clk_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register contents |
| irq_pending | input | 1 | Some enabled interrupt is pending |
| xint_n | input | NX (2) | External interrupt pins, active low |
| xint_en | input | NX (2) | Per-pin interrupt enable |
| xint_level | input | NX (2) | Per-pin level mode (1) or edge mode (0) |
| wake_en | input | 1 | Allows external pins to wake from power-down |
| pd_permit | input | 1 | PD may be set only while high |
| wdt_load | input | 1 | Watchdog timer load event |
| settle_limit | input | STAB_W (16) | Oscillator settling count |
| cpu_clk_en | output | 1 | CPU clock gate |
| per_clk_en | output | 1 | Peripheral clock gate |
| osc_en | output | 1 | Oscillator enable |
| strobe_hold | output | 1 | Strobe pins held at `strobe_level` |
| strobe_level | output | 1 | Level of the held strobes |

## Verification
The hardest path to reach is the complete power-down exit. It needs a pin that is enabled, set to level mode and cleared for wake-up, then a low phase, then a release, and then the settling count has to run out. The stimulus first blocks each qualifier on its own and checks that the oscillator stays off. It then drives a full low-hold-release sequence with two settling counts, one of them zero, and measures the cycles until the CPU clock returns. Writes made during sleep and interrupt requests during power-down are sent at the exact points where they must be ignored.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  typedef enum logic [2:0] {PM_RUN, PM_IDLE, PM_DOWN, PM_WAKE, PM_SETTLE} pm_state_e;

  localparam int B_IDL  = 0;
  localparam int B_PD   = 1;
  localparam int B_WDOG = 4;
  localparam int B_POF  = 5;

  // Merge a write: PD only when permitted, IDL suppressed when PD wins.
  function automatic logic [7:0] write_merge(logic [7:0] wdata, logic permit);
    logic [7:0] v;
    v        = wdata;
    v[B_PD]  = wdata[B_PD] & permit;
    v[B_IDL] = wdata[B_IDL] & ~v[B_PD];
    return v;
  endfunction

  // A pin is a wake source when low, enabled, in level mode, with wake allowed.
  function automatic logic wake_any(logic [7:0] pin_n, logic [7:0] en,
                                    logic [7:0] lvl, logic allow);
    return allow & |(~pin_n & en & lvl);
  endfunction
endpackage

// File: rtl/pmc_ctl_reg.sv
`timescale 1ns/1ps
module pmc_ctl_reg
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ok,
  input  logic [7:0] wdata,
  input  logic       pd_permit,
  input  logic       wdt_load,
  input  logic       pd_clr,
  input  logic       idl_clr,
  output logic [7:0] ctl,
  output logic       pd_set,
  output logic       idl_set
);
  logic [7:0] merged;
  logic [1:0] hi_q;
  logic [4:0] lo_q;
  logic       pof_q;

  assign merged  = write_merge(wdata, pd_permit);
  assign pd_set  = wr_ok & merged[B_PD];
  assign idl_set = wr_ok & merged[B_IDL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_ok) begin
        hi_q <= merged[7:6];
        lo_q <= merged[4:0];
      end
      if (wdt_load) lo_q[B_WDOG] <= 1'b0;
      if (pd_clr)   lo_q[B_PD]   <= 1'b0;
      if (idl_clr)  lo_q[B_IDL]  <= 1'b0;
    end
  end

  // Power-off flag is deliberately outside the reset domain.
  always_ff @(posedge clk) begin
    if (wr_ok) pof_q <= wdata[B_POF];
  end

  assign ctl = {hi_q, pof_q, lo_q};

  AST_PD_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[B_PD]) |-> $past(pd_permit)); // R4
  AST_PD_OVER_IDL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl[B_PD] && ctl[B_IDL])); // R3
  AST_WDOG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_load |=> !ctl[B_WDOG]); // R9
endmodule

// File: rtl/pmc_settle_cnt.sv
`timescale 1ns/1ps
module pmc_settle_cnt #(
  parameter int STAB_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [STAB_W-1:0] limit,
  output logic              done
);
  logic [STAB_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= limit;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R10
endmodule

// File: rtl/pmc_fsm.sv
`timescale 1ns/1ps
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int NX = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_set,
  input  logic          idl_set,
  input  logic          irq_pending,
  input  logic [NX-1:0] xint_n,
  input  logic [NX-1:0] xint_en,
  input  logic [NX-1:0] xint_level,
  input  logic          wake_en,
  input  logic          settle_done,
  output pm_state_e     state,
  output logic          settle_load,
  output logic          pd_clr,
  output logic          idl_clr,
  output logic          wake_req
);
  localparam int PADW = 8 - NX;
  pm_state_e st_q, st_d;

  assign wake_req = wake_any({{PADW{1'b1}}, xint_n}, {{PADW{1'b0}}, xint_en},
                             {{PADW{1'b0}}, xint_level}, wake_en);

  always_comb begin
    st_d        = st_q;
    settle_load = 1'b0;
    pd_clr      = 1'b0;
    idl_clr     = 1'b0;
    unique case (st_q)
      PM_RUN:    if (pd_set) st_d = PM_DOWN; else if (idl_set) st_d = PM_IDLE;
      PM_IDLE:   if (irq_pending) begin st_d = PM_RUN; idl_clr = 1'b1; end
      PM_DOWN:   if (wake_req) st_d = PM_WAKE;
      PM_WAKE:   if (!wake_req) begin st_d = PM_SETTLE; settle_load = 1'b1; end
      PM_SETTLE: if (settle_done) begin st_d = PM_RUN; pd_clr = 1'b1; end
      default:   st_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PM_RUN;
    else        st_q <= st_d;
  end

  assign state = st_q;

  AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_IDLE && irq_pending) |=> (st_q == PM_RUN)); // R5
  AST_DOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_DOWN && !wake_req) |=> (st_q == PM_DOWN)); // R6
  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_WAKE && wake_req) |=> (st_q == PM_WAKE)); // R7
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NX     = 2,
  parameter int STAB_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              irq_pending,
  input  logic [NX-1:0]     xint_n,
  input  logic [NX-1:0]     xint_en,
  input  logic [NX-1:0]     xint_level,
  input  logic              wake_en,
  input  logic              pd_permit,
  input  logic              wdt_load,
  input  logic [STAB_W-1:0] settle_limit,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              strobe_hold,
  output logic              strobe_level
);
  pm_state_e  state;
  logic       wr_ok, pd_set, idl_set, pd_clr, idl_clr;
  logic       settle_load, settle_done, wake_req;
  logic [7:0] ctl;

  assign wr_ok = reg_wr & cpu_clk_en;

  pmc_ctl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wdata(reg_wdata),
    .pd_permit(pd_permit), .wdt_load(wdt_load), .pd_clr(pd_clr),
    .idl_clr(idl_clr), .ctl(ctl), .pd_set(pd_set), .idl_set(idl_set)
  );

  pmc_fsm #(.NX(NX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_set(pd_set), .idl_set(idl_set),
    .irq_pending(irq_pending), .xint_n(xint_n), .xint_en(xint_en),
    .xint_level(xint_level), .wake_en(wake_en), .settle_done(settle_done),
    .state(state), .settle_load(settle_load), .pd_clr(pd_clr),
    .idl_clr(idl_clr), .wake_req(wake_req)
  );

  pmc_settle_cnt #(.STAB_W(STAB_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(settle_load), .limit(settle_limit),
    .done(settle_done)
  );

  assign reg_rdata    = ctl;
  assign cpu_clk_en   = (state == PM_RUN);
  assign per_clk_en   = (state == PM_RUN) || (state == PM_IDLE);
  assign osc_en       = (state != PM_DOWN);
  assign strobe_hold  = (state != PM_RUN);
  assign strobe_level = (state == PM_IDLE);

  AST_PD_CLR_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl[B_PD]) |-> cpu_clk_en); // R11
  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && state == PM_DOWN && !wdt_load && !wake_req) |=> $stable(reg_rdata)); // R12
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        irq_pending = 0;
  logic [1:0]  xint_n = 2'b11;
  logic [1:0]  xint_en = 0;
  logic [1:0]  xint_level = 0;
  logic        wake_en = 0;
  logic        pd_permit = 1;
  logic        wdt_load = 0;
  logic [15:0] settle_limit = 16'd5;
  logic        cpu_clk_en, per_clk_en, osc_en, strobe_hold, strobe_level;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_pending(irq_pending), .xint_n(xint_n),
    .xint_en(xint_en), .xint_level(xint_level), .wake_en(wake_en),
    .pd_permit(pd_permit), .wdt_load(wdt_load), .settle_limit(settle_limit),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .strobe_hold(strobe_hold), .strobe_level(strobe_level)
  );

  // {wdata, permit, cpu per osc hold level, pad, expected read (bit5 masked)}
  localparam logic [23:0] VEC [6] = '{
    {8'h01, 1'b1, 5'b01111, 2'b00, 8'h01},
    {8'h02, 1'b1, 5'b00010, 2'b00, 8'h02},
    {8'h03, 1'b1, 5'b00010, 2'b00, 8'h02},
    {8'h02, 1'b0, 5'b11100, 2'b00, 8'h00},
    {8'h03, 1'b0, 5'b01111, 2'b00, 8'h01},
    {8'hFC, 1'b1, 5'b11100, 2'b00, 8'hDC}
  };

  function automatic logic [4:0] outs();
    return {cpu_clk_en, per_clk_en, osc_en, strobe_hold, strobe_level};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic count_to_run(output int n);
    n = 0;
    while (n < 200) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (cpu_clk_en) break;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    @(negedge clk);
    chk("R2 reset register", reg_rdata & 8'hDF, 8'h00);
    chk("R2 R8 reset outputs", outs(), 5'b11100);

    for (int i = 0; i < 6; i++) begin
      do_reset();
      pd_permit = VEC[i][15];
      wr(VEC[i][23:16]);
      chk("R3 R4 R5 R6 R8 mode outputs", outs(), VEC[i][14:10]);
      chk("R1 R3 R4 readback", reg_rdata & 8'hDF, VEC[i][7:0]);
    end
    pd_permit = 1;

    // R2: bit 5 survives reset
    do_reset();
    wr(8'h20);
    do_reset();
    @(negedge clk);
    chk("R2 pof kept", reg_rdata[5], 1'b1);
    chk("R2 others cleared", reg_rdata & 8'hDF, 8'h00);

    // R9: watchdog load clears bit 4, wins over a same-cycle write
    wr(8'h10);
    chk("R1 wdog bit", reg_rdata[4], 1'b1);
    @(negedge clk); wdt_load = 1; reg_wr = 1; reg_wdata = 8'h10;
    @(negedge clk); wdt_load = 0; reg_wr = 0;
    chk("R9 wdog cleared", reg_rdata[4], 1'b0);

    // R12 and R5: idle ignores writes, irq ends it
    wr(8'h01);
    wr(8'h0C);
    chk("R12 write in idle ignored", reg_rdata & 8'hDF, 8'h01);
    @(negedge clk); irq_pending = 1;
    @(negedge clk); irq_pending = 0;
    chk("R5 idle exit cpu", cpu_clk_en, 1'b1);
    chk("R5 idle bit cleared", reg_rdata[0], 1'b0);

    // R6 / R7: blocked wake attempts
    wr(8'h02);
    @(negedge clk); irq_pending = 1;
    repeat (3) @(negedge clk);
    irq_pending = 0;
    chk("R6 irq ignored in power-down", outs(), 5'b00010);
    xint_en = 2'b11; xint_level = 2'b11; wake_en = 0; xint_n = 2'b10;
    repeat (3) @(negedge clk);
    chk("R6 R7 no wake without wake_en", osc_en, 1'b0);
    wake_en = 1; xint_level = 2'b10;
    repeat (3) @(negedge clk);
    chk("R7 no wake in edge mode", osc_en, 1'b0);
    wr(8'h00);
    chk("R12 write in power-down ignored", reg_rdata & 8'hDF, 8'h02);
    xint_n = 2'b11; xint_level = 2'b11; xint_en = 2'b10;
    @(negedge clk); xint_n = 2'b10;
    repeat (2) @(negedge clk);
    chk("R7 disabled pin no wake", osc_en, 1'b0);
    xint_n = 2'b11; xint_en = 2'b11;

    // R7 R10 R11: full wake with settle count 5
    settle_limit = 16'd5;
    @(negedge clk); xint_n = 2'b10;
    @(negedge clk);
    chk("R7 osc restarts", {osc_en, cpu_clk_en}, 2'b10);
    repeat (3) @(negedge clk);
    chk("R7 cpu held while low", {osc_en, cpu_clk_en}, 2'b10);
    xint_n = 2'b11;
    count_to_run(n);
    chk("R10 settle 5", n, 7);
    chk("R11 pd cleared", reg_rdata[1], 1'b0);
    chk("R8 strobes released", {strobe_hold, per_clk_en}, 2'b01);

    // R10 with zero settle, other pin
    settle_limit = 16'd0;
    wr(8'h02);
    @(negedge clk); xint_n = 2'b01;
    @(negedge clk); xint_n = 2'b11;
    count_to_run(n);
    chk("R10 settle 0", n, 2);

    // R6: reset ends power-down
    wr(8'h02);
    chk("R6 in power-down", osc_en, 1'b0);
    do_reset();
    @(negedge clk);
    chk("R6 reset exits", outs(), 5'b11100);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule